// File: doc/BRIEF.md
# Cascaded 128-Source Interrupt Router

This block gathers 128 level-sensitive interrupt request lines and steers each of them onto one of eight output lines. Outputs 0 to 5 drive the processor's interrupt pins, output 6 is a non-maskable request and output 7 is a debug request. Each source carries a 3-bit routing selector, and a per-source block bit can keep it away from every output. Each output is the OR of all unblocked, active sources whose selector names it.

Software reaches the block through a simple synchronous register port. The 128-bit status and block registers are each split into two 64-bit halves. The half that holds sources 0 to 63 (the "upper" half) sits at the base offset. The half that holds sources 64 to 127 (the "lower" half) sits 0x1000 above it. Bit 0 of the upper half belongs to no source. In the status view it carries a summary of the lower half, so one read tells software whether the lower half needs a second read.

Top module: `casc_intr_mapper`

## Requirements
- R1: After reset every block bit is set (the upper block half reads 0xFFFF_FFFF_FFFF_FFFE and the lower block half reads all ones), every routing selector reads 0, and `irq_o` is 0.
- R2: The register offsets are as follows. Upper status is at 0x000 and the upper block register is at 0x008. The lower versions of both sit at the same offset plus 0x1000. The selector of source s is at 0x400 + 8*(s mod 64), plus 0x1000 when s is 64 or above, in data bits 2:0. Read data appears on `rd_data_o` after the clock edge that samples `rd_en_i` and holds until the next read.
- R3: A status read returns the raw source levels at the sampling edge. The upper half gives sources 63..1 in bits 63..1, and the lower half gives sources 127..64 in bits 63..0.
- R4: Bit 0 of the upper status half is the OR of all lower-half sources whose block bit is clear.
- R5: Selector values 0 to 5 route a source to `irq_o[0]`..`irq_o[5]`. Value 6 routes it to `irq_o[6]` (non-maskable) and value 7 routes it to `irq_o[7]` (debug).
- R6: A source whose block bit is set reaches no output.
- R7: An output stays high while any routed, unblocked source is active, and it falls only when the last one drops.
- R8: `irq_o` changes at the first clock edge after a source change. After a configuration write, it changes at the edge that follows the write edge.
- R9: Writes to either status half are ignored. Bit 0 of the upper block half cannot be written and always reads 0.
- R10: A single write to the upper block half with bits 63:56 all set or all cleared blocks or unblocks mailbox sources 56 to 63 together.
- R11: Source 0 never reaches any output.
- R12: Reads of unmapped offsets return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 128 | Interrupt request levels, bit n is source n |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 13 | Register byte offset |
| wr_data_i | input | 64 | Write data |
| rd_data_o | output | 64 | Registered read data |
| irq_o | output | 8 | Routed requests: 0-5 processor pins, 6 non-maskable, 7 debug |

## Verification
The embedded properties assume three things. Reset is held for at least one clock edge before any activity. Every input is at a known level after reset. The sources are synchronous to the clock, so the value sampled at an edge is the value the router used. The bench holds reset for several edges. It changes sources, strobes, address and data only on falling clock edges, and it drives every input to a defined value from time zero. Strobes are held for exactly one rising edge, so each access is sampled exactly once.

// File: rtl/casc_intr_pkg.sv
package casc_intr_pkg;

   // Kind of register an offset selects
   typedef enum logic [1:0] {
      RK_NONE   = 2'd0,
      RK_STATUS = 2'd1,
      RK_BLOCK  = 2'd2,
      RK_ROUTE  = 2'd3
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e kind;
      logic      low_half;
   } reg_sel_t;

endpackage

// File: rtl/intmap_decode.sv
module intmap_decode #(
   parameter int ADDR_W    = 13,
   parameter int HALF_W    = 64,
   parameter int LOW_OFS   = 'h1000,
   parameter int STAT_OFS  = 'h000,
   parameter int BLOCK_OFS = 'h008,
   parameter int ROUTE_OFS = 'h400,
   localparam int IDX_W    = $clog2(HALF_W)
) (
   input  logic [ADDR_W-1:0]          addr_i,
   output casc_intr_pkg::reg_sel_t    sel_o,
   output logic [IDX_W-1:0]           idx_o
);
   import casc_intr_pkg::*;

   localparam int LOW_BIT = $clog2(LOW_OFS);
   localparam logic [ADDR_W-1:0] LOW_A   = ADDR_W'(LOW_OFS);
   localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] BLOCK_A = ADDR_W'(BLOCK_OFS);
   localparam logic [ADDR_W-1:0] ROUTE_A = ADDR_W'(ROUTE_OFS);
   localparam logic [ADDR_W-1:0] ROUTE_SPAN = ADDR_W'(8 * HALF_W);

   if ((1 << LOW_BIT) != LOW_OFS || LOW_BIT >= ADDR_W) begin : g_bad_low
      $error("LOW_OFS must be a power of two inside the address range");
   end
   if (ROUTE_OFS + 8 * HALF_W > LOW_OFS) begin : g_bad_route
      $error("selector window overlaps the lower half");
   end

   logic [ADDR_W-1:0] off;
   logic [ADDR_W-1:0] rel;

   always_comb begin
      off            = addr_i & ~LOW_A;
      rel            = off - ROUTE_A;
      sel_o.low_half = addr_i[LOW_BIT];
      idx_o          = rel[IDX_W+2:3];
      if (off == STAT_A)
         sel_o.kind = RK_STATUS;
      else if (off == BLOCK_A)
         sel_o.kind = RK_BLOCK;
      else if (rel < ROUTE_SPAN && rel[2:0] == 3'b000)
         sel_o.kind = RK_ROUTE;
      else
         sel_o.kind = RK_NONE;
   end

endmodule

// File: rtl/intmap_cfg.sv
module intmap_cfg #(
   parameter int HALF_W  = 64,
   parameter int NUM_OUT = 8,
   localparam int NUM_SRC = 2 * HALF_W,
   localparam int SEL_W   = $clog2(NUM_OUT),
   localparam int IDX_W   = $clog2(HALF_W)
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_en_i,
   input  logic                       rd_en_i,
   input  casc_intr_pkg::reg_sel_t    sel_i,
   input  logic [IDX_W-1:0]           idx_i,
   input  logic [HALF_W-1:0]          wr_data_i,
   input  logic [HALF_W-1:1]          src_up_i,
   input  logic [HALF_W-1:0]          src_lo_i,
   output logic [NUM_SRC-1:0]         block_o,
   output logic [NUM_SRC*SEL_W-1:0]   route_o,
   output logic [HALF_W-1:0]          rd_data_o
);
   import casc_intr_pkg::*;

   logic [HALF_W-1:1]  block_up_q;
   logic [HALF_W-1:0]  block_lo_q;
   logic [SEL_W-1:0]   route_q [NUM_SRC];
   logic [HALF_W-1:0]  rd_q;
   logic [HALF_W-1:0]  rd_mux;
   logic               summary;
   logic [IDX_W:0]     ent;

   assign ent     = {sel_i.low_half, idx_i};
   assign summary = |(src_lo_i & ~block_lo_q);

   // Source 0 has no enable of its own: it stays blocked for good
   assign block_o = {block_lo_q, block_up_q, 1'b1};

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_flat
      assign route_o[s*SEL_W +: SEL_W] = route_q[s];
   end

   always_comb begin
      case (sel_i.kind)
         RK_STATUS: rd_mux = sel_i.low_half ? src_lo_i : {src_up_i, summary};
         RK_BLOCK:  rd_mux = sel_i.low_half ? block_lo_q : {block_up_q, 1'b0};
         RK_ROUTE:  rd_mux = {{(HALF_W-SEL_W){1'b0}}, route_q[ent]};
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         block_up_q <= '1;
         block_lo_q <= '1;
         rd_q       <= '0;
         for (int s = 0; s < NUM_SRC; s++) route_q[s] <= '0;
      end else begin
         if (wr_en_i) begin
            case (sel_i.kind)
               RK_BLOCK: begin
                  if (sel_i.low_half) block_lo_q <= wr_data_i;
                  else                block_up_q <= wr_data_i[HALF_W-1:1];
               end
               RK_ROUTE: route_q[ent] <= wr_data_i[SEL_W-1:0];
               default: ;
            endcase
         end
         if (rd_en_i) rd_q <= rd_mux;
      end
   end

   assign rd_data_o = rd_q;

   // R1: block registers leave reset fully set
   a_r1_reset_blocked: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (&block_up_q && &block_lo_q));

   // R9: a status write leaves the block registers alone
   a_r9_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
      (wr_en_i && sel_i.kind == RK_STATUS) |=> ($stable(block_up_q) && $stable(block_lo_q)));

   // R9: bit 0 of the upper block half reads back as 0
   a_r9_block_bit0_zero: assert property (@(posedge clk) disable iff (rst)
      (rd_en_i && sel_i.kind == RK_BLOCK && !sel_i.low_half) |=> (rd_data_o[0] == 1'b0));

   // R4: with the lower half fully blocked the summary bit is clear
   a_r4_summary_blocked: assert property (@(posedge clk) disable iff (rst)
      (rd_en_i && sel_i.kind == RK_STATUS && !sel_i.low_half && &block_lo_q)
      |=> (rd_data_o[0] == 1'b0));

   // R12: unmapped offsets read as zero
   a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
      (rd_en_i && sel_i.kind == RK_NONE) |=> (rd_data_o == '0));

endmodule

// File: rtl/intmap_router.sv
module intmap_router #(
   parameter int NUM_SRC = 128,
   parameter int NUM_OUT = 8,
   localparam int SEL_W  = $clog2(NUM_OUT)
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_SRC-1:0]         src_i,
   input  logic [NUM_SRC-1:0]         block_i,
   input  logic [NUM_SRC*SEL_W-1:0]   route_i,
   output logic [NUM_OUT-1:0]         irq_o
);

   logic [NUM_OUT-1:0] irq_d;
   logic [NUM_OUT-1:0] irq_q;

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      logic [NUM_SRC-1:0] hit;
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         assign hit[s] = src_i[s] & ~block_i[s]
                       & (route_i[s*SEL_W +: SEL_W] == SEL_W'(o));
      end
      assign irq_d[o] = |hit;
   end

   always_ff @(posedge clk) begin
      if (rst) irq_q <= '0;
      else     irq_q <= irq_d;
   end

   assign irq_o = irq_q;

   // R6: nothing leaves when every source is blocked
   a_r6_all_blocked_quiet: assert property (@(posedge clk) disable iff (rst)
      (&block_i) |=> (irq_o == '0));

   // R7: no active unblocked source means all outputs low next cycle
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      (~|(src_i & ~block_i)) |=> (irq_o == '0));

   // R5: every selector value names an output, so activity always shows
   a_r5_active_reaches_output: assert property (@(posedge clk) disable iff (rst)
      (|(src_i & ~block_i)) |=> (|irq_o));

   // R8: outputs move only one edge after their inputs moved
   a_r8_output_follows_inputs: assert property (@(posedge clk) disable iff (rst)
      ($stable(src_i) && $stable(block_i) && $stable(route_i)) |=> $stable(irq_o));

endmodule

// File: rtl/casc_intr_mapper.sv
module casc_intr_mapper #(
   parameter int HALF_W    = 64,
   parameter int NUM_OUT   = 8,
   parameter int ADDR_W    = 13,
   parameter int LOW_OFS   = 'h1000,
   parameter int STAT_OFS  = 'h000,
   parameter int BLOCK_OFS = 'h008,
   parameter int ROUTE_OFS = 'h400,
   localparam int NUM_SRC  = 2 * HALF_W,
   localparam int SEL_W    = $clog2(NUM_OUT),
   localparam int IDX_W    = $clog2(HALF_W)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [127:0]        src_i,
   input  logic                wr_en_i,
   input  logic                rd_en_i,
   input  logic [12:0]         addr_i,
   input  logic [63:0]         wr_data_i,
   output logic [63:0]         rd_data_o,
   output logic [7:0]          irq_o
);
   import casc_intr_pkg::*;

   if (HALF_W < 2 || (HALF_W & (HALF_W - 1)) != 0) begin : g_bad_half
      $error("HALF_W must be a power of two of at least 2");
   end
   if (NUM_SRC != 128 || HALF_W != 64) begin : g_bad_src
      $error("the port list is sized for 128 sources in 64-bit halves");
   end
   if (NUM_OUT != 8 || (1 << SEL_W) != NUM_OUT) begin : g_bad_out
      $error("NUM_OUT must be 8 so that every selector value names an output");
   end
   if (ADDR_W != 13) begin : g_bad_addr
      $error("the port list is sized for a 13-bit offset");
   end

   reg_sel_t                 sel;
   logic [IDX_W-1:0]         idx;
   logic [NUM_SRC-1:0]       block;
   logic [NUM_SRC*SEL_W-1:0] route;

   intmap_decode #(
      .ADDR_W(ADDR_W), .HALF_W(HALF_W), .LOW_OFS(LOW_OFS),
      .STAT_OFS(STAT_OFS), .BLOCK_OFS(BLOCK_OFS), .ROUTE_OFS(ROUTE_OFS)
   ) u_decode (
      .addr_i (addr_i),
      .sel_o  (sel),
      .idx_o  (idx)
   );

   intmap_cfg #(.HALF_W(HALF_W), .NUM_OUT(NUM_OUT)) u_cfg (
      .clk       (clk),
      .rst       (rst),
      .wr_en_i   (wr_en_i),
      .rd_en_i   (rd_en_i),
      .sel_i     (sel),
      .idx_i     (idx),
      .wr_data_i (wr_data_i),
      .src_up_i  (src_i[HALF_W-1:1]),
      .src_lo_i  (src_i[NUM_SRC-1:HALF_W]),
      .block_o   (block),
      .route_o   (route),
      .rd_data_o (rd_data_o)
   );

   intmap_router #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_router (
      .clk     (clk),
      .rst     (rst),
      .src_i   (src_i),
      .block_i (block),
      .route_i (route),
      .irq_o   (irq_o)
   );

   // R11: source 0 alone never raises an output
   a_r11_source0_inert: assert property (@(posedge clk) disable iff (rst)
      (src_i[NUM_SRC-1:1] == '0) |=> (irq_o == '0));

endmodule

// File: tb/casc_intr_mapper_bench.sv
module casc_intr_mapper_bench;

   localparam logic [12:0] A_STAT_UP  = 13'h0000;
   localparam logic [12:0] A_BLOCK_UP = 13'h0008;
   localparam logic [12:0] A_STAT_LO  = 13'h1000;
   localparam logic [12:0] A_BLOCK_LO = 13'h1008;
   localparam logic [12:0] A_UNMAPPED = 13'h0010;
   localparam logic [63:0] ONES = {64{1'b1}};

   // {source pattern, expected irq} with selector of source s = s mod 8
   localparam int NVEC = 8;
   localparam logic [135:0] VEC [NVEC] = '{
      {(128'd1 << 9),                 8'h02},  // R5 pin 1
      {(128'd1 << 70),                8'h40},  // R5 non-maskable
      {(128'd1 << 127),               8'h80},  // R5 debug
      {((128'd1 << 3) | (128'd1 << 12)), 8'h18}, // R5 two pins
      {(128'd1 << 0),                 8'h00},  // R11 source 0
      {(128'd1 << 8),                 8'h01},  // R5 pin 0
      {{128{1'b1}},                   8'hFF},  // R7 all sources
      {(128'd1 << 64),                8'h01}   // R5 lower half
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [127:0] src = '0;
   logic         wr_en = 1'b0;
   logic         rd_en = 1'b0;
   logic [12:0]  addr = '0;
   logic [63:0]  wdata = '0;
   logic [63:0]  rdata;
   logic [7:0]   irq;
   logic [63:0]  got;
   int           n_chk = 0;
   int           n_fail = 0;
   bit           done = 1'b0;

   always #2 clk = ~clk;

   casc_intr_mapper u_casc_intr_mapper (
      .clk       (clk),
      .rst       (rst),
      .src_i     (src),
      .wr_en_i   (wr_en),
      .rd_en_i   (rd_en),
      .addr_i    (addr),
      .wr_data_i (wdata),
      .rd_data_o (rdata),
      .irq_o     (irq)
   );

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [12:0] a, input logic [63:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [12:0] a, output logic [63:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   function automatic logic [12:0] route_addr(input int s);
      return ((s >= 64) ? 13'h1000 : 13'h0000) + 13'h0400 + 13'(8 * (s % 64));
   endfunction

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      chk("R1 irq after reset", irq, 0);
      reg_rd(A_BLOCK_UP, got); chk("R1 upper block reset", got, 64'hFFFF_FFFF_FFFF_FFFE);
      reg_rd(A_BLOCK_LO, got); chk("R1 lower block reset", got, ONES);
      reg_rd(route_addr(100), got); chk("R1 selector reset", got, 0);

      // R6 everything blocked, R3/R4 raw status and summary
      @(negedge clk); src = {128{1'b1}};
      @(negedge clk); chk("R6 blocked sources quiet", irq, 0);
      reg_rd(A_STAT_UP, got); chk("R3 R4 upper status, summary blocked", got, 64'hFFFF_FFFF_FFFF_FFFE);
      reg_rd(A_STAT_LO, got); chk("R3 lower status raw", got, ONES);

      // R9 status writes and block bit 0
      reg_wr(A_STAT_UP, 64'h0);
      reg_rd(A_STAT_UP, got); chk("R9 status write ignored", got, 64'hFFFF_FFFF_FFFF_FFFE);
      reg_wr(A_BLOCK_UP, 64'h1);
      reg_rd(A_BLOCK_UP, got); chk("R9 block bit0 not writable", got, 64'h0);
      reg_wr(A_BLOCK_UP, ONES);
      reg_rd(A_BLOCK_UP, got); chk("R9 block bit0 reads zero", got, 64'hFFFF_FFFF_FFFF_FFFE);

      // selectors s mod 8
      @(negedge clk); src = '0;
      for (int s = 0; s < 128; s++) reg_wr(route_addr(s), 64'(s % 8));
      reg_rd(route_addr(77), got); chk("R2 selector readback", got, 64'd5);
      reg_wr(A_BLOCK_UP, 64'h0);
      reg_wr(A_BLOCK_LO, 64'h0);

      // R4 summary, R2 lower-half offset
      @(negedge clk); src = 128'd1 << 64;
      reg_rd(A_STAT_UP, got); chk("R4 summary set", got, 64'h1);
      reg_wr(A_BLOCK_LO, 64'h1);
      reg_rd(A_STAT_UP, got); chk("R4 R2 summary honours lower block", got, 64'h0);
      reg_rd(A_STAT_LO, got); chk("R3 lower status unaffected by block", got, 64'h1);
      reg_rd(A_BLOCK_UP, got); chk("R2 upper block untouched", got, 64'h0);
      reg_wr(A_BLOCK_LO, 64'h0);

      // R5 R7 R11 vector table
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk); src = VEC[i][135:8];
         @(negedge clk); chk("R5 R7 R11 routing vector", irq, VEC[i][7:0]);
      end

      // R7 OR of several sources
      @(negedge clk); src = (128'd1 << 9) | (128'd1 << 17);
      @(negedge clk); chk("R7 two sources", irq, 8'h02);
      src = 128'd1 << 17;
      @(negedge clk); chk("R7 one source left", irq, 8'h02);
      src = '0;
      @(negedge clk); chk("R7 last source dropped", irq, 8'h00);

      // R8 latency
      src = 128'd1 << 9;
      #1 chk("R8 no change before edge", irq, 8'h00);
      @(negedge clk); chk("R8 one edge after source", irq, 8'h02);
      reg_wr(route_addr(9), 64'd5);
      chk("R8 unchanged at write edge", irq, 8'h02);
      @(negedge clk); chk("R8 new route after next edge", irq, 8'h20);

      // R10 mailbox group
      src = 128'hFF << 56;
      @(negedge clk); chk("R10 mailbox open", irq, 8'hFF);
      reg_wr(A_BLOCK_UP, 64'hFF00_0000_0000_0000);
      @(negedge clk); chk("R10 mailbox group blocked", irq, 8'h00);
      reg_wr(A_BLOCK_UP, 64'h0);
      @(negedge clk); chk("R10 mailbox group reopened", irq, 8'hFF);

      // R12 unmapped offsets
      reg_rd(A_UNMAPPED, got); chk("R12 unmapped read", got, 64'h0);
      reg_wr(A_UNMAPPED, ONES);
      reg_rd(A_BLOCK_UP, got); chk("R12 unmapped write harmless", got, 64'h0);
      chk("R12 outputs unchanged", irq, 8'hFF);

      summary();
   end

endmodule